// File: doc/BRIEF.md
# Repeat-Mode Instruction Sequencer

This controller replays a held instruction, or an even/odd pair of held instructions, for a given number of passes without fetching them again. Between passes it moves the operand addresses on, either by adding a fixed step or, in linked mode, by following a pointer taken from the word just read. It decides whether to stop from a pass counter and from the result flags of the execution unit.

The caller issues one command while the block is idle. The command carries the mode, the start addresses, a step, a pass count (or a request to take the count from the dedicated count register input), per-operand hold and write bits, and a stop mask. The block then drives a one-access-at-a-time execution port. When it finishes it pulses `done` and presents both working addresses and the runout flag. Interrupt requests are held back for the whole run, because a half-finished repeat cannot be resumed.

Top module: `repseq_top`

## Requirements
- R1: After reset `busy`, `done`, `mem_valid` and `err_align` are low, and `irq_out` follows `irq_in`.
- R2: Mode 0 (single; mode 3 behaves the same) makes one access per pass, at address A. The low half `cmd_insn[35:0]` is driven on `exe_insn` and `cmd_write[0]` on `mem_write`. A is advanced by `cmd_incr` after each pass. A count of 0 means 256 passes.
- R3: Mode 1 (double) makes two accesses per pass: first at A with `cmd_insn[35:0]` and `cmd_write[0]`, then at B with `cmd_insn[71:36]` and `cmd_write[1]`. The stop test uses the flags of the second access.
- R4: A double-mode command whose `cmd_iaddr[0]` is 1 is refused. `err_align` is high for exactly the one cycle after the command, no access is made and `busy` stays low.
- R5: When `cmd_use_x0` is 1, the pass count comes from `x0_count` and `cmd_count` is ignored.
- R6: `cmd_hold[0]` keeps A unchanged and `cmd_hold[1]` keeps B unchanged on every pass. Without its hold bit, B advances by `cmd_incr` each pass in every mode.
- R7: If `res_flags & cmd_stop_mask` is nonzero for the deciding access of a pass, the run ends after that pass. This holds even on the last counted pass. `tally_runout` is then 0, and `fin_addr_a`/`fin_addr_b` hold the addresses last accessed.
- R8: If all passes run without a stop, `tally_runout` is 1 and the final addresses are advanced past the last pass.
- R9: Mode 2 (linked) takes the next A from `rd_data[35:18]` of the word just read instead of adding the step.
- R10: `irq_out` is 0 whenever `busy` or `done` is high, and equals `irq_in` otherwise.
- R11: Only one access is outstanding. Address and strobe hold while `mem_ready` is low. With `mem_ready` held high a run is busy for exactly 2 cycles per pass in single or linked mode and 3 in double mode.
- R12: `done` is a one-cycle pulse with `busy` low, and it follows the last busy cycle.
- R13: Addresses are 18 bits and wrap modulo 2^18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_mode | input | 2 | 0 single, 1 double, 2 linked, 3 single |
| cmd_iaddr | input | 18 | Address of the first held instruction |
| cmd_insn | input | 72 | Held instruction pair, first in the low half |
| cmd_count | input | 8 | Immediate pass count, 0 means 256 |
| cmd_use_x0 | input | 1 | Take the count from x0_count |
| x0_count | input | 8 | Run-time count from the count register |
| cmd_incr | input | 18 | Address step per pass |
| cmd_addr_a | input | 18 | Start address of operand A |
| cmd_addr_b | input | 18 | Start address of operand B |
| cmd_hold | input | 2 | Per-operand step suppression (bit 0 A, bit 1 B) |
| cmd_write | input | 2 | Per-operand write strobe (bit 0 A, bit 1 B) |
| cmd_stop_mask | input | 4 | Flags that end the run early |
| busy | output | 1 | Run in progress |
| mem_valid | output | 1 | Access request |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_addr | output | 18 | Operand address |
| mem_write | output | 1 | 1 write, 0 read |
| exe_insn | output | 36 | Instruction being replayed |
| res_flags | input | 4 | Result flags of the accepted access |
| rd_data | input | 36 | Word read by the accepted access |
| irq_in | input | 1 | Incoming interrupt request |
| irq_out | output | 1 | Interrupt request after masking |
| done | output | 1 | One-cycle end-of-run pulse |
| fin_addr_a | output | 18 | Working address A |
| fin_addr_b | output | 18 | Working address B |
| tally_runout | output | 1 | Run ended by count exhaustion |
| err_align | output | 1 | Odd-aligned double command refused |

## Verification
The bench aims at the pass where a stop flag and the last count coincide: a design that lets the count win would report runout and an advanced address. It aims at the count of zero, which must give 256 passes rather than none or a wrap. A run that takes its count from the register input would show the wrong number of accesses if the source select were swapped. Address wrap at the top of the 18-bit space is covered, as is the linked chain, where a design that adds the step would leave the pointer chain at once. Random back-pressure shows whether an address moves while a request is stalled. The odd-aligned double command shows whether a refused command still starts accesses.

// File: rtl/repseq_pkg.sv
package repseq_pkg;
  localparam logic [1:0] MODE_ONE  = 2'd0;
  localparam logic [1:0] MODE_PAIR = 2'd1;
  localparam logic [1:0] MODE_LINK = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OP_A = 3'd1,
    ST_OP_B = 3'd2,
    ST_STEP = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/repseq_tally.sv
module repseq_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W:0]   remaining,
  output logic             last
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= (load_val == '0) ? FULL : {1'b0, load_val};
    end else if (dec) begin
      remaining <= remaining - ONE;
    end
  end

  assign last = (remaining == ONE);
endmodule

// File: rtl/repseq_addr.sv
module repseq_addr #(
  parameter int ADDR_W = 18,
  parameter int N_OPS  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [N_OPS-1:0][ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0]            incr,
  input  logic [N_OPS-1:0]             hold,
  input  logic                         step,
  input  logic                         link_en,
  input  logic [ADDR_W-1:0]            link_val,
  output logic [N_OPS-1:0][ADDR_W-1:0] addr
);
  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    if (i == 0) begin : g_lead
      always_ff @(posedge clk) begin
        if (rst) addr[i] <= '0;
        else if (load) addr[i] <= start[i];
        else if (step) begin
          if (link_en) addr[i] <= link_val;
          else if (!hold[i]) addr[i] <= addr[i] + incr;
        end
      end
    end else begin : g_follow
      always_ff @(posedge clk) begin
        if (rst) addr[i] <= '0;
        else if (load) addr[i] <= start[i];
        else if (step && !hold[i]) addr[i] <= addr[i] + incr;
      end
    end
  end
endmodule

// File: rtl/repseq_top.sv
module repseq_top
  import repseq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 36,
  parameter int CNT_W  = 8,
  parameter int FLAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_mode,
  input  logic [ADDR_W-1:0]     cmd_iaddr,
  input  logic [2*WORD_W-1:0]   cmd_insn,
  input  logic [CNT_W-1:0]      cmd_count,
  input  logic                  cmd_use_x0,
  input  logic [CNT_W-1:0]      x0_count,
  input  logic [ADDR_W-1:0]     cmd_incr,
  input  logic [ADDR_W-1:0]     cmd_addr_a,
  input  logic [ADDR_W-1:0]     cmd_addr_b,
  input  logic [1:0]            cmd_hold,
  input  logic [1:0]            cmd_write,
  input  logic [FLAG_W-1:0]     cmd_stop_mask,
  output logic                  busy,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_write,
  output logic [WORD_W-1:0]     exe_insn,
  input  logic [FLAG_W-1:0]     res_flags,
  input  logic [WORD_W-1:0]     rd_data,
  input  logic                  irq_in,
  output logic                  irq_out,
  output logic                  done,
  output logic [ADDR_W-1:0]     fin_addr_a,
  output logic [ADDR_W-1:0]     fin_addr_b,
  output logic                  tally_runout,
  output logic                  err_align
);
  localparam int N_OPS   = 2;
  localparam int PAIR_W  = 2 * WORD_W;
  localparam int LINK_LO = WORD_W - ADDR_W;

  seq_state_e state_q, state_d;
  logic [1:0]              mode_q, hold_q, we_q;
  logic [FLAG_W-1:0]       mask_q, flags_q;
  logic [PAIR_W-1:0]       insn_q;
  logic [ADDR_W-1:0]       link_q;
  logic                    tally_q, err_q;
  logic                    accept, reject, launch, stop_now, step_en, pass_last;
  logic                    in_access, fire;
  logic [CNT_W:0]          passes_left;
  logic [N_OPS-1:0][ADDR_W-1:0] op_addr;
  logic                    unused_bits;

  assign accept    = (state_q == ST_IDLE) && cmd_valid;
  assign reject    = accept && (cmd_mode == MODE_PAIR) && cmd_iaddr[0];
  assign launch    = accept && !reject;
  assign stop_now  = |(flags_q & mask_q);
  assign step_en   = (state_q == ST_STEP) && !stop_now;
  assign in_access = (state_q == ST_OP_A) || (state_q == ST_OP_B);
  assign fire      = in_access && mem_ready;
  assign unused_bits = ^{rd_data[LINK_LO-1:0], cmd_iaddr[ADDR_W-1:1], passes_left};

  repseq_tally #(.CNT_W(CNT_W)) u_tally (
    .clk       (clk),
    .rst       (rst),
    .load      (launch),
    .load_val  (cmd_use_x0 ? x0_count : cmd_count),
    .dec       (state_q == ST_STEP),
    .remaining (passes_left),
    .last      (pass_last)
  );

  repseq_addr #(.ADDR_W(ADDR_W), .N_OPS(N_OPS)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (launch),
    .start    ({cmd_addr_b, cmd_addr_a}),
    .incr     (cmd_incr_q),
    .hold     (hold_q),
    .step     (step_en),
    .link_en  (mode_q == MODE_LINK),
    .link_val (link_q),
    .addr     (op_addr)
  );

  logic [ADDR_W-1:0] cmd_incr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_OP_A;
      ST_OP_A: if (mem_ready) state_d = (mode_q == MODE_PAIR) ? ST_OP_B : ST_STEP;
      ST_OP_B: if (mem_ready) state_d = ST_STEP;
      ST_STEP: state_d = (stop_now || pass_last) ? ST_FIN : ST_OP_A;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_ONE;
      hold_q     <= '0;
      we_q       <= '0;
      mask_q     <= '0;
      flags_q    <= '0;
      insn_q     <= '0;
      link_q     <= '0;
      cmd_incr_q <= '0;
      tally_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= reject;
      if (launch) begin
        mode_q     <= cmd_mode;
        hold_q     <= cmd_hold;
        we_q       <= cmd_write;
        mask_q     <= cmd_stop_mask;
        insn_q     <= cmd_insn;
        cmd_incr_q <= cmd_incr;
        flags_q    <= '0;
        tally_q    <= 1'b0;
      end
      if (fire) flags_q <= res_flags;
      if (fire && state_q == ST_OP_A) link_q <= rd_data[WORD_W-1:LINK_LO];
      if (step_en && pass_last) tally_q <= 1'b1;
    end
  end

  assign busy         = in_access || (state_q == ST_STEP);
  assign done         = (state_q == ST_FIN);
  assign mem_valid    = in_access;
  assign mem_addr     = (state_q == ST_OP_B) ? op_addr[1] : op_addr[0];
  assign mem_write    = (state_q == ST_OP_B) ? we_q[1] : we_q[0];
  assign exe_insn     = (state_q == ST_OP_B) ? insn_q[PAIR_W-1:WORD_W] : insn_q[WORD_W-1:0];
  assign irq_out      = irq_in && (state_q == ST_IDLE);
  assign fin_addr_a   = op_addr[0];
  assign fin_addr_b   = op_addr[1];
  assign tally_runout = tally_q;
  assign err_align    = err_q;
endmodule

// File: rtl/repseq_chk.sv
module repseq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_write,
  input logic              irq_out,
  input logic              done,
  input logic              err_align
);
  assert_no_idle_access_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (busy || done) |-> !irq_out);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_reject_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    err_align |-> (!busy && !mem_valid));
endmodule

bind repseq_top repseq_chk #(.ADDR_W(ADDR_W)) u_repseq_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_write (mem_write),
  .irq_out   (irq_out),
  .done      (done),
  .err_align (err_align)
);

// File: tb/repseq_top_test.sv
module repseq_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_mode = '0;
  logic [17:0] cmd_iaddr = '0;
  logic [71:0] cmd_insn = '0;
  logic [7:0]  cmd_count = '0;
  logic        cmd_use_x0 = 1'b0;
  logic [7:0]  x0_count = '0;
  logic [17:0] cmd_incr = '0;
  logic [17:0] cmd_addr_a = '0;
  logic [17:0] cmd_addr_b = '0;
  logic [1:0]  cmd_hold = '0;
  logic [1:0]  cmd_write = '0;
  logic [3:0]  cmd_stop_mask = '0;
  logic        busy, mem_valid, mem_write, irq_out, done, tally_runout, err_align;
  logic        mem_ready = 1'b0;
  logic [17:0] mem_addr, fin_addr_a, fin_addr_b;
  logic [35:0] exe_insn;
  logic [3:0]  res_flags = '0;
  logic [35:0] rd_data = '0;
  logic        irq_in = 1'b1;

  repseq_top uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_iaddr(cmd_iaddr), .cmd_insn(cmd_insn), .cmd_count(cmd_count),
    .cmd_use_x0(cmd_use_x0), .x0_count(x0_count), .cmd_incr(cmd_incr),
    .cmd_addr_a(cmd_addr_a), .cmd_addr_b(cmd_addr_b), .cmd_hold(cmd_hold),
    .cmd_write(cmd_write), .cmd_stop_mask(cmd_stop_mask), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_write(mem_write), .exe_insn(exe_insn), .res_flags(res_flags),
    .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out), .done(done),
    .fin_addr_a(fin_addr_a), .fin_addr_b(fin_addr_b),
    .tally_runout(tally_runout), .err_align(err_align)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // responder and access log
  bit          force_ready = 1'b1;
  logic [17:0] hit_addr = '0;
  int          log_n = 0;
  int          irq_bad = 0;
  logic [17:0] lg_addr [0:1023];
  logic        lg_we   [0:1023];
  logic [35:0] lg_insn [0:1023];
  logic [17:0] ex_addr [0:1023];
  logic        ex_we   [0:1023];
  logic [35:0] ex_insn [0:1023];

  function automatic logic [17:0] link_of(input logic [17:0] a);
    return 18'((a * 7) + 11);
  endfunction

  function automatic logic [3:0] flag_of(input logic [17:0] a);
    return {2'b00, a[0], a == hit_addr};
  endfunction

  always @(negedge clk) begin
    bit rdy;
    rdy = force_ready ? 1'b1 : (($urandom % 4) != 0);
    mem_ready = rdy;
    res_flags = flag_of(mem_addr);
    rd_data   = {link_of(mem_addr), ~mem_addr};
    if (mem_valid && rdy && log_n < 1024) begin
      lg_addr[log_n] = mem_addr;
      lg_we[log_n]   = mem_write;
      lg_insn[log_n] = exe_insn;
      log_n++;
    end
    if ((busy || done) && irq_out) irq_bad++;
    if (!busy && !done && (irq_out != irq_in)) irq_bad++;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run(input string rq, input logic [1:0] md, input logic [17:0] ia,
                     input logic [7:0] cnt, input bit ux, input logic [7:0] x0,
                     input logic [17:0] inc, input logic [17:0] a0, input logic [17:0] b0,
                     input logic [1:0] hold, input logic [1:0] wr, input logic [3:0] mask,
                     input logic [71:0] insn, input bit fr, input bit chk_time);
    int n, ne, busy_cyc, waited, bad, first_bad;
    bit stopped, got;
    logic [17:0] a, b, last_a, fa, fb;
    logic tal;
    n = ux ? int'(x0) : int'(cnt);
    if (n == 0) n = 256;
    a = a0; b = b0; ne = 0; stopped = 1'b0;
    for (int p = 0; p < n; p++) begin
      ex_addr[ne] = a; ex_we[ne] = wr[0]; ex_insn[ne] = insn[35:0]; ne++;
      last_a = a;
      if (md == 2'd1) begin
        ex_addr[ne] = b; ex_we[ne] = wr[1]; ex_insn[ne] = insn[71:36]; ne++;
        last_a = b;
      end
      if (|(flag_of(last_a) & mask)) begin
        stopped = 1'b1;
        break;
      end
      if (md == 2'd2) a = link_of(a);
      else if (!hold[0]) a = a + inc;
      if (!hold[1]) b = b + inc;
    end

    @(negedge clk);
    log_n = 0; irq_bad = 0; force_ready = fr;
    cmd_mode = md; cmd_iaddr = ia; cmd_count = cnt; cmd_use_x0 = ux; x0_count = x0;
    cmd_incr = inc; cmd_addr_a = a0; cmd_addr_b = b0; cmd_hold = hold;
    cmd_write = wr; cmd_stop_mask = mask; cmd_insn = insn; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_cyc = 0; waited = 0; got = 1'b0; fa = '0; fb = '0; tal = 1'b0;
    while (!got && waited < 6000) begin
      if (busy) busy_cyc++;
      if (done) begin
        got = 1'b1; fa = fin_addr_a; fb = fin_addr_b; tal = tally_runout;
      end else begin
        @(negedge clk);
        waited++;
      end
    end
    chk(got, "R12", {rq, " run reached done"}, 64'(got), 64'd1);
    @(negedge clk);
    chk(!done && !busy, "R12", {rq, " done lasts one cycle"}, 64'(done), 64'd0);
    chk(log_n == ne, rq, "access count", 64'(log_n), 64'(ne));
    bad = 0; first_bad = -1;
    for (int i = 0; i < ne && i < log_n; i++) begin
      if (lg_addr[i] !== ex_addr[i] || lg_we[i] !== ex_we[i] || lg_insn[i] !== ex_insn[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(bad == 0, rq, "access sequence (addr/strobe/insn)",
        (first_bad < 0) ? 64'd0 : 64'(lg_addr[first_bad]),
        (first_bad < 0) ? 64'd0 : 64'(ex_addr[first_bad]));
    chk(fa == a, stopped ? "R7" : "R8", {rq, " final address A"}, 64'(fa), 64'(a));
    chk(fb == b, "R6", {rq, " final address B"}, 64'(fb), 64'(b));
    chk(tal == !stopped, stopped ? "R7" : "R8", {rq, " runout flag"}, 64'(tal), 64'(!stopped));
    chk(irq_bad == 0, "R10", {rq, " interrupt masking"}, 64'(irq_bad), 64'd0);
    if (chk_time)
      chk(busy_cyc == n * ((md == 2'd1) ? 3 : 2), "R11", {rq, " busy cycles per pass"},
          64'(busy_cyc), 64'(n * ((md == 2'd1) ? 3 : 2)));
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_valid && !err_align, "R1", "idle after reset",
        64'({busy, done, mem_valid, err_align}), 64'd0);
    chk(irq_out == irq_in, "R1", "irq passes when idle", 64'(irq_out), 64'(irq_in));

    // R2 single mode, timing R11
    hit_addr = 18'h3ffff;
    run("R2", 2'd0, 18'h10, 8'd4, 1'b0, 8'd0, 18'd2, 18'h100, 18'h200,
        2'b00, 2'b01, 4'h0, 72'h0aa_bbbb_cccc_1234_5678, 1'b1, 1'b1);
    // R2 count zero means 256 passes
    run("R2", 2'd3, 18'h11, 8'd0, 1'b0, 8'd0, 18'd1, 18'h400, 18'h0,
        2'b00, 2'b00, 4'h0, 72'h1, 1'b1, 1'b1);
    // R5 count from the register input, immediate ignored
    run("R5", 2'd0, 18'h12, 8'd9, 1'b1, 8'd3, 18'd4, 18'h40, 18'h80,
        2'b00, 2'b00, 4'h0, 72'h2, 1'b1, 1'b1);
    // R5 register count of zero
    run("R5", 2'd0, 18'h12, 8'd2, 1'b1, 8'd0, 18'd1, 18'h800, 18'h0,
        2'b00, 2'b00, 4'h0, 72'h3, 1'b1, 1'b0);
    // R3 double mode, even pair
    run("R3", 2'd1, 18'h20, 8'd5, 1'b0, 8'd0, 18'd1, 18'h1000, 18'h2000,
        2'b00, 2'b10, 4'h0, 72'hfe_dcba_9876_5432_10ff, 1'b1, 1'b1);
    // R6 hold B, then hold A
    run("R6", 2'd1, 18'h22, 8'd4, 1'b0, 8'd0, 18'd2, 18'h3000, 18'h5000,
        2'b10, 2'b10, 4'h0, 72'h55_0000_0000_0000_0077, 1'b1, 1'b0);
    run("R6", 2'd0, 18'h23, 8'd3, 1'b0, 8'd0, 18'd2, 18'h3000, 18'h5000,
        2'b01, 2'b00, 4'h0, 72'h66, 1'b1, 1'b0);
    // R7 early stop on pass 4 of 10 (address 0x600 + 3*2)
    hit_addr = 18'h606;
    run("R7", 2'd0, 18'h30, 8'd10, 1'b0, 8'd0, 18'd2, 18'h600, 18'h0,
        2'b00, 2'b00, 4'h1, 72'h7, 1'b1, 1'b0);
    // R7 stop on the last counted pass beats runout
    run("R7", 2'd0, 18'h30, 8'd4, 1'b0, 8'd0, 18'd2, 18'h600, 18'h0,
        2'b00, 2'b00, 4'h1, 72'h8, 1'b1, 1'b0);
    // R7 stop on second operand in double mode
    hit_addr = 18'h902;
    run("R7", 2'd1, 18'h40, 8'd8, 1'b0, 8'd0, 18'd1, 18'h700, 18'h900,
        2'b00, 2'b00, 4'h1, 72'h9, 1'b1, 1'b0);
    // R9 linked chain, then linked with a stop
    hit_addr = 18'h3ffff;
    run("R9", 2'd2, 18'h50, 8'd6, 1'b0, 8'd0, 18'd5, 18'h123, 18'h0,
        2'b00, 2'b00, 4'h0, 72'ha, 1'b1, 1'b1);
    hit_addr = link_of(link_of(18'h123));
    run("R9", 2'd2, 18'h50, 8'd6, 1'b0, 8'd0, 18'd5, 18'h123, 18'h0,
        2'b00, 2'b00, 4'h1, 72'hb, 1'b1, 1'b0);
    // R13 wrap
    hit_addr = 18'h3ffff;
    run("R13", 2'd0, 18'h60, 8'd3, 1'b0, 8'd0, 18'd3, 18'h3fffe, 18'h3fffd,
        2'b00, 2'b00, 4'h0, 72'hc, 1'b1, 1'b0);

    // R4 odd-aligned double command is refused
    @(negedge clk);
    log_n = 0;
    cmd_mode = 2'd1; cmd_iaddr = 18'h31; cmd_count = 8'd3; cmd_use_x0 = 1'b0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err_align && !busy && !mem_valid, "R4", "refusal pulse",
        64'({err_align, busy, mem_valid}), 64'h4);
    @(negedge clk);
    chk(!err_align && !busy, "R4", "refusal one cycle", 64'({err_align, busy}), 64'd0);
    repeat (3) @(negedge clk);
    chk(log_n == 0, "R4", "no access after refusal", 64'(log_n), 64'd0);

    // random runs with back-pressure (R2 R3 R9 R11)
    for (int k = 0; k < 40; k++) begin
      logic [1:0]  md;
      logic [17:0] a0, inc;
      md  = 2'($urandom % 3);
      a0  = 18'($urandom);
      inc = 18'($urandom % 9);
      hit_addr = a0 + inc * 18'($urandom % 6);
      run((md == 2'd1) ? "R3" : ((md == 2'd2) ? "R9" : "R2"), md,
          18'($urandom) & 18'h3fffe, 8'(1 + $urandom % 12), 1'($urandom),
          8'(1 + $urandom % 12), inc, a0, 18'($urandom), 2'($urandom),
          2'($urandom), 4'($urandom) & 4'h3,
          {8'($urandom), 32'($urandom), 32'($urandom)}, 1'b0, 1'b0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule